// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block arbitrates interrupt requests for a small 8-bit microcontroller core and turns the winning request into a vectored call. Three hardware sources feed it: an overflow strobe from each of two 8-bit timers and a completion strobe from the serial interface. The serial strobe covers both a finished 8-bit transfer and a received matching slave address. Each source has a latched pending flag and an enable bit. A single global enable gates all of them.

A call is issued only at an instruction boundary, and only when the core's return stack has room. When the call is issued, the controller pulses a call request with the vector address for one cycle. In the same clock edge it clears the serviced flag and the global enable. The core pushes only its program counter, so any other state is the handler's job to save. The controller also drives a wake-up output for power-down mode, which is raised whenever any flag is pending, masked or not.

The core reaches the state through one 8-bit control register. It is written by a write strobe and read back combinationally.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all flags, all source enables and the global enable are 0, and `call_req`, `call_vec` and `wake` are 0.
- R2: A strobe on `src_evt[i]` sets flag i at the next clock edge. The flag then stays set, even while its enable is off, until it is serviced or written to zero.
- R3: A call is issued only when all of the following hold in the same cycle: the global enable is 1, the source's enable is 1, its flag is set, `stack_full` is 0 and `insn_bound` is 1.
- R4: `call_vec` is 0x08 for timer 0 (source 0), 0x0C for timer 1 (source 1) and 0x14 for the serial source (source 2). It is 0 when no call is issued.
- R5: When several sources are eligible in one cycle, source 0 wins over source 1, and source 1 wins over source 2.
- R6: `call_req` is a one-cycle pulse, registered one edge after the eligible cycle. In that same edge the serviced flag and the global enable are cleared.
- R7: Control register layout. Bit 0 is the global enable. Bits 1 to 3 are the enables of sources 0 to 2. Bits 4 to 6 are the flags of sources 0 to 2. Bit 7 reads 0. A write with `ctl_wr` loads all enables from the data. In the flag positions, a written 0 clears the flag and a written 1 leaves it unchanged.
- R8: A hardware strobe on a flag wins over a software clear or a service clear of that flag in the same cycle.
- R9: `wake` is 1 exactly when any flag is set. It does not depend on the global enable, the source enables, `stack_full` or `insn_bound`.
- R10: The serial source is eligible only while `ser_mod_on` is 1. Its flag latches regardless of `ser_mod_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | 3 | Request strobes: bit 0 timer 0, bit 1 timer 1, bit 2 serial |
| ser_mod_on | input | 1 | Serial module enabled |
| insn_bound | input | 1 | Core is at an instruction boundary |
| stack_full | input | 1 | Core return stack has no free entry |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read view |
| call_req | output | 1 | One-cycle vectored call request |
| call_vec | output | 8 | Vector address for the call |
| wake | output | 1 | Wake-up from power-down |

## Verification
The bench builds the block with its defaults: three sources, an 8-bit vector, and vectors 0x08, 0x0C and 0x14. With only three sources, random strobes and register writes frequently put two or three eligible flags in the same cycle, so every priority pairing occurs many times. Random writes also produce a set strobe and a clear of the same flag in one cycle. Directed sequences add the remaining cases: draining all three flags in turn, holding the serial source off through its module enable, and blocking a call while the stack is full.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC   = 3;
  localparam int REG_W  = 8;
  localparam int SRC_T0  = 0;
  localparam int SRC_T1  = 1;
  localparam int SRC_SER = 2;
  // control register positions
  localparam int POS_GIE = 0;
  localparam int POS_EN  = 1;
  localparam int POS_FLG = POS_EN + NSRC;
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank
  import irqv_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] svc_clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flags_d[i] = flags_q[i];
      if (sw_clr[i] || svc_clr[i]) flags_d[i] = 1'b0;
      if (hw_set[i])               flags_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end

    // a strobe always leaves its flag set one edge later
    assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hw_set[i]) |-> flags_q[i]);
  end

  assign flags = flags_q;
endmodule

// File: rtl/irqv_enable_reg.sv
module irqv_enable_reg
  import irqv_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_gie,
  input  logic [N-1:0] wr_src_en,
  input  logic         take,
  output logic         gie,
  output logic [N-1:0] src_en
);
  logic         gie_q, gie_d;
  logic [N-1:0] en_q, en_d;

  always_comb begin
    gie_d = gie_q;
    en_d  = en_q;
    if (wr_en) begin
      gie_d = wr_gie;
      en_d  = wr_src_en;
    end
    if (take) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_d;
      en_q  <= en_d;
    end
  end

  assert_take_drops_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) |-> !gie_q);

  assign gie    = gie_q;
  assign src_en = en_q;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int                N     = NSRC,
  parameter int                VEC_W = 8,
  parameter logic [VEC_W-1:0]  VEC_T0  = 8'h08,
  parameter logic [VEC_W-1:0]  VEC_T1  = 8'h0C,
  parameter logic [VEC_W-1:0]  VEC_SER = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     src_en,
  input  logic [N-1:0]     src_ok,
  input  logic             gie,
  input  logic             stack_full,
  input  logic             insn_bound,
  output logic [N-1:0]     grant,
  output logic             take,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  localparam logic [N-1:0][VEC_W-1:0] VTAB = {VEC_SER, VEC_T1, VEC_T0};

  logic [N-1:0]     elig;
  logic [VEC_W-1:0] vec_d;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  assign elig = flags & src_en & src_ok;

  // fixed priority: lowest index first
  always_comb begin
    grant = '0;
    vec_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        vec_d = VTAB[i];
      end
    end
  end

  assign take = gie && !stack_full && insn_bound && (|elig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= take;
      vec_q <= take ? vec_d : '0;
    end
  end

  assign call_req = req_q;
  assign call_vec = vec_q;

  assert_call_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_call_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(gie) && !$past(stack_full) && $past(insn_bound)));
  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (vec_q == VEC_T0 || vec_q == VEC_T1 || vec_q == VEC_SER));
  assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (vec_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_T0  = 8'h08,
  parameter logic [VEC_W-1:0] VEC_T1  = 8'h0C,
  parameter logic [VEC_W-1:0] VEC_SER = 8'h14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             ser_mod_on,
  input  logic             insn_bound,
  input  logic             stack_full,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             wake
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NSRC-1:0] flags, src_en, src_ok, grant, sw_clr, svc_clr;
  logic            gie, take;

  assign sw_clr  = ctl_wr ? ~ctl_wdata[POS_FLG +: NSRC] : '0;
  assign svc_clr = take ? grant : '0;

  always_comb begin
    src_ok          = '1;
    src_ok[SRC_SER] = ser_mod_on;
  end

  irqv_flag_bank #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .hw_set  (src_evt),
    .sw_clr  (sw_clr),
    .svc_clr (svc_clr),
    .flags   (flags)
  );

  irqv_enable_reg #(.N(NSRC)) u_enables (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (ctl_wr),
    .wr_gie    (ctl_wdata[POS_GIE]),
    .wr_src_en (ctl_wdata[POS_EN +: NSRC]),
    .take      (take),
    .gie       (gie),
    .src_en    (src_en)
  );

  irqv_arbiter #(
    .N       (NSRC),
    .VEC_W   (VEC_W),
    .VEC_T0  (VEC_T0),
    .VEC_T1  (VEC_T1),
    .VEC_SER (VEC_SER)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .flags      (flags),
    .src_en     (src_en),
    .src_ok     (src_ok),
    .gie        (gie),
    .stack_full (stack_full),
    .insn_bound (insn_bound),
    .grant      (grant),
    .take       (take),
    .call_req   (call_req),
    .call_vec   (call_vec)
  );

  always_comb begin
    ctl_rdata                     = '0;
    ctl_rdata[POS_GIE]            = gie;
    ctl_rdata[POS_EN +: NSRC]     = src_en;
    ctl_rdata[POS_FLG +: NSRC]    = flags;
  end

  assign wake = |flags;

  assert_wake_before_call_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    call_req |-> $past(wake));
  assert_ser_needs_mod_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (call_req && call_vec == VEC_SER) |-> $past(ser_mod_on));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_evt;
  logic       ser_mod_on, insn_bound, stack_full, ctl_wr;
  logic [7:0] ctl_wdata, ctl_rdata, call_vec;
  logic       call_req, wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state
  logic       m_gie;
  logic [2:0] m_en, m_flg;
  logic       m_req;
  logic [7:0] m_vec;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .ser_mod_on(ser_mod_on),
    .insn_bound(insn_bound), .stack_full(stack_full), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .call_req(call_req),
    .call_vec(call_vec), .wake(wake)
  );

  function automatic logic [7:0] vec_of(input int idx);
    case (idx)
      0: return 8'h08;
      1: return 8'h0C;
      default: return 8'h14;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata();
    return {1'b0, m_flg, m_en, m_gie};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(call_req === m_req, tag, "call_req", {7'b0, call_req}, {7'b0, m_req});
    check(call_vec === m_vec, tag, "call_vec", call_vec, m_vec);
    check(ctl_rdata === exp_rdata(), tag, "ctl_rdata", ctl_rdata, exp_rdata());
    check(wake === (|m_flg), tag, "wake", {7'b0, wake}, {7'b0, |m_flg});
  endtask

  // one cycle: drive at negedge, update model, compare at following negedge
  task automatic step(input logic [2:0] evt, input logic wr, input logic [7:0] wd,
                      input logic bound, input logic full, input logic son,
                      input string tag);
    logic [2:0] elig, clr, grant;
    logic       tk;
    src_evt = evt; ctl_wr = wr; ctl_wdata = wd;
    insn_bound = bound; stack_full = full; ser_mod_on = son;
    elig  = m_flg & m_en & {son, 2'b11};
    grant = 3'b000;
    for (int i = 2; i >= 0; i--) if (elig[i]) grant = 3'b001 << i;
    tk    = m_gie && !full && bound && (|elig);
    clr   = (wr ? ~wd[6:4] : 3'b000) | (tk ? grant : 3'b000);
    m_req = tk;
    m_vec = 8'h00;
    for (int i = 0; i < 3; i++) if (tk && grant[i]) m_vec = vec_of(i);
    m_flg = (m_flg & ~clr) | evt;
    if (wr) begin m_gie = wd[0]; m_en = wd[3:1]; end
    if (tk) m_gie = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=%h exp=%h", 8'h00, 8'h01);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; src_evt = 0; ser_mod_on = 0; insn_bound = 0;
    stack_full = 0; ctl_wr = 0; ctl_wdata = 0;
    m_gie = 0; m_en = 0; m_flg = 0; m_req = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release");

    // R2 / R9: latch while disabled, wake without global enable
    step(3'b010, 0, 8'h00, 1, 0, 1, "R2 set t1 disabled");
    repeat (3) step(3'b000, 0, 8'h00, 1, 1, 1, "R2 hold / R9 wake");
    // R8: hw set beats sw clear in same cycle
    step(3'b010, 1, 8'h00, 1, 0, 1, "R8 set vs clear");
    step(3'b000, 1, 8'h0F, 1, 0, 1, "R7 clear flags keep");
    // R3: stack full blocks with everything enabled
    step(3'b001, 0, 8'h00, 1, 0, 1, "R2 set t0");
    step(3'b000, 1, 8'h7F, 1, 1, 1, "R7 enable all");
    repeat (2) step(3'b000, 0, 8'h00, 1, 1, 1, "R3 stack full");
    step(3'b000, 0, 8'h00, 0, 0, 1, "R3 no boundary");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R3 take t0");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R6 pulse ends");
    // R5 / R4: three pending, drain in order
    step(3'b111, 0, 8'h00, 1, 0, 1, "R2 set all");
    step(3'b000, 1, 8'h7F, 1, 0, 1, "R7 gie on");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R5 t0 first");
    step(3'b000, 1, 8'h7F, 1, 0, 1, "R7 gie on");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R5 t1 second");
    // R10: serial blocked while module off
    step(3'b000, 1, 8'h7F, 1, 0, 0, "R10 gie on");
    repeat (3) step(3'b000, 0, 8'h00, 1, 0, 0, "R10 module off");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R10 module on");
    step(3'b000, 0, 8'h00, 1, 0, 1, "R4 ser vector");
    step(3'b000, 1, 8'h00, 1, 0, 1, "R7 clear all");

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      logic [2:0] e;
      logic w;
      logic [7:0] d;
      e[0] = ($urandom % 8) == 0;
      e[1] = ($urandom % 8) == 0;
      e[2] = ($urandom % 8) == 0;
      w    = ($urandom % 5) == 0;
      d    = 8'($urandom);
      if (($urandom % 2) == 0) d[3:1] = 3'b111;
      step(e, w, d, ($urandom % 4) != 0, ($urandom % 5) == 0,
           ($urandom % 4) != 0, "R3/R4/R5/R6/R7/R8/R9 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule